// File: doc/BRIEF.md
# SPI Phase-Zero Master Transfer Engine

This block is the master side of an SPI link that uses clock phase zero. A host writes one byte into the transmit register. If the engine is idle, that write starts a full-duplex 8-bit exchange. The engine pulls the active-low select line low and puts the first data bit on the serial output at the same moment. It then waits a programmable lead time and produces sixteen serial clock edges. Received bits are captured on the odd-numbered edges, and the outgoing bit changes on the even-numbered edges. A programmable trail time follows, then select is released. The engine stays busy for a programmable idle gap before it accepts the next byte.

Clock polarity and bit order can be chosen. The serial clock half period is a programmable number of system clocks, so the SCK period is always an even divisor of the system clock. Lead, trail and idle times are counted in half SCK periods. Incoming bits are gathered in a shift register. The whole byte is copied into a separate receive register only when the sixteenth edge occurs, which gives double buffering. A completion flag is set at that same edge and stays set until the host reads the receive register. If a second byte completes while the flag is still set, an overrun flag is raised and the earlier byte is kept. A write to the transmit register while the engine is busy is dropped and raises a write-collision flag.

The controller states are ST_IDLE, ST_LEAD, ST_XFER, ST_TRAIL and ST_GAP. The transitions are:
- ST_IDLE to ST_LEAD on an accepted write.
- ST_LEAD to ST_XFER on the first SCK edge, after the last lead half period.
- ST_XFER to ST_TRAIL on the sixteenth edge.
- ST_TRAIL to ST_GAP on the last trail half period, where select rises.
- ST_GAP to ST_IDLE on the last idle half period.

Top module: `spi_p0_engine`

## Requirements
- R1: After reset, ss_n is 1, busy is 0, sck equals cfg_cpol, and done_flag, ovr_flag and wcol_flag are all 0.
- R2: While select is high, sck rests at the level of cfg_cpol. Each transfer produces exactly 16 sck transitions.
- R3: The first data bit is on mosi in the same cycle that ss_n falls. mosi changes only on even-numbered edges (2, 4, ..., 14), never on odd-numbered edges.
- R4: With cfg_lsb_first 0, tx_data bit 7 is sent first and bit 0 last. With cfg_lsb_first 1, bit 0 is sent first and bit 7 last. Each bit is valid on mosi at odd edge 2j+1 for bit slot j.
- R5: miso is sampled on odd-numbered edges, and the bit order of R4 also applies to receive. rx_data keeps its previous value through the first 15 edges and takes the new byte at the 16th edge.
- R6: done_flag rises at the 16th edge. It stays 1 until an rx_rd pulse, which clears it together with ovr_flag.
- R7: The time from ss_n falling to the first sck edge is max(cfg_lead,1) × max(cfg_half_div,1) system clocks.
- R8: The time from the 16th sck edge to ss_n rising is max(cfg_trail,1) × max(cfg_half_div,1) system clocks.
- R9: After ss_n rises, busy stays 1 for max(cfg_idle,1) × max(cfg_half_div,1) system clocks, then drops to 0.
- R10: Consecutive sck edges are max(cfg_half_div,1) system clocks apart.
- R11: A tx_wr while busy is 1 does not change the byte being sent and sets wcol_flag. The next accepted tx_wr clears wcol_flag.
- R12: When a transfer completes while done_flag is still 1, ovr_flag is set and rx_data keeps the earlier byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | SCK rest level |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_half_div | input | DIV_W | System clocks per SCK half period (0 treated as 1) |
| cfg_lead | input | DLY_W | Lead time in half periods (0 treated as 1) |
| cfg_trail | input | DLY_W | Trail time in half periods (0 treated as 1) |
| cfg_idle | input | DLY_W | Idle gap in half periods (0 treated as 1) |
| tx_wr | input | 1 | Transmit register write strobe |
| tx_data | input | DATA_W | Byte to send |
| rx_rd | input | 1 | Receive register read strobe |
| rx_data | output | DATA_W | Receive data register |
| done_flag | output | 1 | Transfer complete |
| ovr_flag | output | 1 | Receive overrun |
| wcol_flag | output | 1 | Write collision |
| busy | output | 1 | Transfer or idle gap in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
Some properties are checked by the embedded assertions on every cycle:
- The serial clock rests at its base level in ST_IDLE and holds still during the trail.
- Edges occur only while select is low.
- mosi moves only on a load or a shift.
- The receive register changes only at completion, and is held when an overrun is flagged.
- A collision flag always comes from a write made while busy.

Other behaviour can only be shown by the bench scenarios:
- The exact bit order on both lines.
- The lead, trail and idle durations as products of the configuration.
- The clearing of flags by the host read.

The bench sweeps both polarities, both bit orders and three divisors.

// File: rtl/spi_p0_pkg.sv
package spi_p0_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_XFER  = 3'd2,
        ST_TRAIL = 3'd3,
        ST_GAP   = 3'd4
    } eng_state_t;

endpackage

// File: rtl/spi_p0_tick.sv
module spi_p0_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] half_eff;
    logic [DIV_W-1:0] hcnt;

    assign half_eff = (half_div == '0) ? ONE : half_div;
    assign tick     = run && (hcnt >= half_eff - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
        end else if (!run || tick) begin
            hcnt <= '0;
        end else begin
            hcnt <= hcnt + ONE;
        end
    end

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> hcnt == '0); // R10

endmodule

// File: rtl/spi_p0_shift.sv
module spi_p0_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              lsb_first,
    input  logic [DATA_W-1:0] load_data,
    input  logic              sample,
    input  logic              shift,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [DATA_W-1:0] tx_rev;
    logic [DATA_W-1:0] rx_rev;
    logic              order_q;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rev
        assign tx_rev[gi] = load_data[DATA_W-1-gi];
        assign rx_rev[gi] = rx_sr[DATA_W-1-gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            order_q <= 1'b0;
        end else if (load) begin
            tx_sr   <= lsb_first ? tx_rev : load_data;
            order_q <= lsb_first;
        end else if (shift) begin
            tx_sr   <= {tx_sr[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (sample) begin
            rx_sr <= {rx_sr[DATA_W-2:0], miso};
        end
    end

    assign mosi    = tx_sr[DATA_W-1];
    assign rx_word = order_q ? rx_rev : rx_sr;

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(mosi)); // R3

endmodule

// File: rtl/spi_p0_rxbuf.sv
module spi_p0_rxbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              complete,
    input  logic [DATA_W-1:0] word,
    input  logic              rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              done,
    output logic              ovr
);
    logic [DATA_W-1:0] data_n;
    logic              done_n;
    logic              ovr_n;

    always_comb begin
        data_n = rx_data;
        done_n = done & ~rd;
        ovr_n  = ovr & ~rd;
        if (complete) begin
            if (done_n) begin
                ovr_n = 1'b1;
            end else begin
                data_n = word;
                done_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            done    <= 1'b0;
            ovr     <= 1'b0;
        end else begin
            rx_data <= data_n;
            done    <= done_n;
            ovr     <= ovr_n;
        end
    end

    AST_DONE_FROM_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(complete)); // R6
    AST_DATA_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !complete |=> $stable(rx_data)); // R5
    AST_OVR_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $stable(rx_data)); // R12

endmodule

// File: rtl/spi_p0_engine.sv
module spi_p0_engine
    import spi_p0_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_lsb_first,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic [DLY_W-1:0]  cfg_lead,
    input  logic [DLY_W-1:0]  cfg_trail,
    input  logic [DLY_W-1:0]  cfg_idle,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              done_flag,
    output logic              ovr_flag,
    output logic              wcol_flag,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);
    localparam int EDGES  = 2 * DATA_W;
    localparam int ECNT_W = $clog2(EDGES);
    localparam logic [ECNT_W-1:0] LAST_EDGE = ECNT_W'(EDGES - 1);
    localparam logic [DLY_W-1:0]  D_ONE     = {{(DLY_W-1){1'b0}}, 1'b1};

    eng_state_t        state;
    eng_state_t        nxt;
    logic              tick;
    logic [DLY_W-1:0]  dcnt;
    logic [DLY_W-1:0]  dly_lim;
    logic              dly_last;
    logic [ECNT_W-1:0] ecnt;
    logic [ECNT_W-1:0] eidx;
    logic              sck_lvl;
    logic              start;
    logic              edge_ev;
    logic              sample_ev;
    logic              shift_ev;
    logic              last_ev;
    logic              wcol_q;
    logic [DATA_W-1:0] rx_word;

    function automatic logic [DLY_W-1:0] at_least1(input logic [DLY_W-1:0] v);
        return (v == '0) ? D_ONE : v;
    endfunction

    // delay limit of the current waiting state
    always_comb begin
        unique case (state)
            ST_LEAD:  dly_lim = at_least1(cfg_lead);
            ST_TRAIL: dly_lim = at_least1(cfg_trail);
            ST_GAP:   dly_lim = at_least1(cfg_idle);
            default:  dly_lim = D_ONE;
        endcase
    end

    assign dly_last  = (dcnt >= dly_lim - D_ONE);
    assign start     = (state == ST_IDLE) && tx_wr;
    assign edge_ev   = tick && (((state == ST_LEAD) && dly_last) || (state == ST_XFER));
    assign eidx      = (state == ST_XFER) ? ecnt : '0;
    assign sample_ev = edge_ev && !eidx[0];
    assign shift_ev  = edge_ev && eidx[0] && (eidx != LAST_EDGE);
    assign last_ev   = edge_ev && (eidx == LAST_EDGE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (tx_wr)             nxt = ST_LEAD;
            ST_LEAD:  if (edge_ev)           nxt = ST_XFER;
            ST_XFER:  if (last_ev)           nxt = ST_TRAIL;
            ST_TRAIL: if (tick && dly_last)  nxt = ST_GAP;
            ST_GAP:   if (tick && dly_last)  nxt = ST_IDLE;
            default:                         nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ss_n = 1'b0;
        busy = 1'b1;
        unique case (state)
            ST_IDLE:  begin ss_n = 1'b1; busy = 1'b0; end
            ST_LEAD:  ss_n = 1'b0;
            ST_XFER:  ss_n = 1'b0;
            ST_TRAIL: ss_n = 1'b0;
            ST_GAP:   ss_n = 1'b1;
            default:  begin ss_n = 1'b1; busy = 1'b0; end
        endcase
        sck       = sck_lvl ^ cfg_cpol;
        wcol_flag = wcol_q;
    end

    // counters, clock level and collision flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt    <= '0;
            ecnt    <= '0;
            sck_lvl <= 1'b0;
            wcol_q  <= 1'b0;
        end else begin
            if (state != nxt) begin
                dcnt <= '0;
            end else if (tick) begin
                dcnt <= dcnt + D_ONE;
            end

            if (start) begin
                ecnt <= '0;
            end else if (edge_ev) begin
                ecnt <= eidx + 1'b1;
            end

            if (state == ST_IDLE) begin
                sck_lvl <= 1'b0;
            end else if (edge_ev) begin
                sck_lvl <= ~sck_lvl;
            end

            if (start) begin
                wcol_q <= 1'b0;
            end else if (tx_wr) begin
                wcol_q <= 1'b1;
            end
        end
    end

    spi_p0_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state != ST_IDLE),
        .half_div (cfg_half_div),
        .tick     (tick)
    );

    spi_p0_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .lsb_first (cfg_lsb_first),
        .load_data (tx_data),
        .sample    (sample_ev),
        .shift     (shift_ev),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );

    spi_p0_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .complete (last_ev),
        .word     (rx_word),
        .rd       (rx_rd),
        .rx_data  (rx_data),
        .done     (done_flag),
        .ovr      (ovr_flag)
    );

    AST_SCK_RESTS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> sck_lvl == 1'b0); // R2
    AST_EDGE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        edge_ev |-> !ss_n); // R7
    AST_TRAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRAIL && $past(state) == ST_TRAIL) |-> $stable(sck_lvl)); // R8
    AST_WCOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol_flag) |-> $past(tx_wr && busy)); // R11

endmodule

// File: tb/spi_p0_engine_bench.sv
module spi_p0_engine_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpol = 1'b0, cfg_lsb_first = 1'b0;
    logic [7:0] cfg_half_div = 8'd1;
    logic [3:0] cfg_lead = 4'd1, cfg_trail = 4'd1, cfg_idle = 4'd1;
    logic       tx_wr = 1'b0, rx_rd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic       done_flag, ovr_flag, wcol_flag, busy, sck, mosi, miso, ss_n;

    always #4 clk = ~clk;

    spi_p0_engine u_spi_p0_engine (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_lsb_first(cfg_lsb_first),
        .cfg_half_div(cfg_half_div), .cfg_lead(cfg_lead), .cfg_trail(cfg_trail),
        .cfg_idle(cfg_idle), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
        .rx_data(rx_data), .done_flag(done_flag), .ovr_flag(ovr_flag),
        .wcol_flag(wcol_flag), .busy(busy), .sck(sck), .mosi(mosi), .miso(miso),
        .ss_n(ss_n)
    );

    int nvec = 0, nbad = 0, cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // slave model and line monitor
    logic [7:0] slv = 8'h00;
    logic [7:0] cap = 8'h00, rx_mid = 8'h00;
    logic       mosi_first = 1'b0, per_bad = 1'b0;
    logic       ss_q = 1'b1, sck_q = 1'b0, busy_q = 1'b0;
    int ecount = 0, t_ssf = 0, t_e1 = 0, t_elast = 0, t_ssr = 0, t_bf = 0, t_prev = 0;

    function automatic int slot(input int j);
        return cfg_lsb_first ? j : 7 - j;
    endfunction

    assign miso = (ecount < 16) ? slv[slot(ecount / 2)] : 1'b0;

    always @(negedge clk) begin
        if (ss_q && !ss_n) begin
            t_ssf = cyc; mosi_first = mosi; ecount = 0; per_bad = 1'b0;
        end
        if (!ss_n && sck !== sck_q) begin
            ecount++;
            if (ecount == 1) t_e1 = cyc;
            else if (cyc - t_prev != int'(cfg_half_div)) per_bad = 1'b1;
            t_prev = cyc; t_elast = cyc;
            if (ecount % 2 == 1 && ecount < 16) cap[slot((ecount - 1) / 2)] = mosi;
            if (ecount == 15) rx_mid = rx_data;
        end
        if (!ss_q && ss_n) t_ssr = cyc;
        if (busy_q && !busy) t_bf = cyc;
        ss_q = ss_n; sck_q = sck; busy_q = busy;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy && k < 5000) begin @(negedge clk); k++; end
        if (k >= 5000) chk(0, "watchdog busy", k, 0);
        @(negedge clk);
    endtask

    task automatic pulse_rd();
        rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0; @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] t, input logic [7:0] s,
                        input logic [7:0] exp_rx, input bit do_read);
        logic [7:0] pre;
        int h, l, tr, id;
        h  = int'(cfg_half_div); l = int'(cfg_lead); tr = int'(cfg_trail); id = int'(cfg_idle);
        slv = s; pre = rx_data;
        @(negedge clk);
        chk(sck == cfg_cpol, "R2 idle level", sck, cfg_cpol);
        tx_data = t; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
        wait_idle();
        chk(ecount == 16, "R2 edge count", ecount, 16);
        chk(sck == cfg_cpol, "R2 rest after", sck, cfg_cpol);
        chk(mosi_first == (cfg_lsb_first ? t[0] : t[7]), "R3 first bit", mosi_first,
            cfg_lsb_first ? t[0] : t[7]);
        chk(cap == t, "R4 mosi byte", cap, t);
        chk(rx_mid == pre, "R5 rx held", rx_mid, pre);
        chk(rx_data == exp_rx, "R5 rx byte", rx_data, exp_rx);
        chk(done_flag == 1'b1, "R6 done set", done_flag, 1);
        chk(t_e1 - t_ssf == l * h, "R7 lead", t_e1 - t_ssf, l * h);
        chk(t_ssr - t_elast == tr * h, "R8 trail", t_ssr - t_elast, tr * h);
        chk(t_bf - t_ssr == id * h, "R9 idle", t_bf - t_ssr, id * h);
        chk(!per_bad, "R10 half period", per_bad, 0);
        if (do_read) begin
            pulse_rd();
            chk(done_flag == 1'b0, "R6 done cleared", done_flag, 0);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        chk(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ss_n == 1'b1, "R1 ss_n", ss_n, 1);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(sck == 1'b0, "R1 sck", sck, 0);
        chk(done_flag == 1'b0 && ovr_flag == 1'b0 && wcol_flag == 1'b0, "R1 flags",
            {done_flag, ovr_flag, wcol_flag}, 0);

        // sweep polarity, order and divisor
        for (int cp = 0; cp < 2; cp++) begin
            for (int lb = 0; lb < 2; lb++) begin
                for (int h = 1; h <= 3; h++) begin
                    logic [7:0] tb, sb;
                    cfg_cpol = cp[0]; cfg_lsb_first = lb[0];
                    cfg_half_div = 8'(h);
                    cfg_lead = 4'(h); cfg_trail = 4'(4 - h); cfg_idle = 4'(1 + cp + lb);
                    tb = 8'hA5 ^ 8'((cp * 6 + lb * 3 + h) * 37);
                    sb = {tb[3:0], tb[7:4]} ^ 8'h3C;
                    xfer(tb, sb, sb, 1'b1);
                    xfer(~tb, ~sb, ~sb, 1'b1);
                end
            end
        end

        // R11 write collision
        cfg_cpol = 1'b0; cfg_lsb_first = 1'b0; cfg_half_div = 8'd2;
        cfg_lead = 4'd1; cfg_trail = 4'd1; cfg_idle = 4'd1;
        slv = 8'h96;
        tx_data = 8'hA5; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
        repeat (5) @(negedge clk);
        tx_data = 8'h3C; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0; tx_data = 8'h00;
        chk(wcol_flag == 1'b1, "R11 wcol set", wcol_flag, 1);
        wait_idle();
        chk(cap == 8'hA5, "R11 byte unchanged", cap, 8'hA5);
        pulse_rd();
        tx_data = 8'h5A; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
        chk(wcol_flag == 1'b0, "R11 wcol cleared", wcol_flag, 0);
        wait_idle();
        pulse_rd();

        // R12 overrun keeps earlier byte
        xfer(8'h11, 8'h5A, 8'h5A, 1'b0);
        chk(ovr_flag == 1'b0, "R12 no ovr yet", ovr_flag, 0);
        xfer(8'h22, 8'hC3, 8'h5A, 1'b0);
        chk(ovr_flag == 1'b1, "R12 ovr set", ovr_flag, 1);
        pulse_rd();
        chk(ovr_flag == 1'b0 && done_flag == 1'b0, "R6 read clears flags",
            {ovr_flag, done_flag}, 0);

        summary();
    end
endmodule